// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a synchronous static RAM with a 32-bit data path and a depth set by parameter. Every control, address and data input is captured in a register on the rising clock edge. The array is accessed on the following edge, and an output register presents read data one edge after that. A host starts an access by pulsing one of two start strobes. One strobe belongs to a processor and the other to a cache controller. After a start, a two-bit counter walks through the other three words of the aligned four-word group. It uses either a linear or an interleaved order, and it steps only while the advance input is low.

Writes can cover any mix of the four byte lanes, or all of them through a single global write input. Three chip selects of mixed polarity must all agree before a start is accepted. A start strobe seen while the part is not selected ends any running burst. A sleep input freezes all accesses and keeps the contents. After sleep is released, a fixed wake-up delay of several cycles passes before accesses are accepted again. The output enable acts on the output port without waiting for a clock. The bidirectional data bus is modelled as a write-data input, a read-data output and a valid flag.

Top module: `burst_sram`

## Requirements
- R1: A read presented on the pins before rising edge N shows its word on `rdata`, with `rvalid` high, after rising edge N+2. `rvalid` is high for exactly that one cycle.
- R2: With `gw_n` high and `bwe_n` low, each lane i whose `bw_n[i]` is 0 writes bits 8i+7:8i. Lane 0 is bits 7:0 and lane 3 is bits 31:24. Lanes whose `bw_n` bit is 1 keep their old contents.
- R3: With `gw_n` low, all four lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R4: With `gw_n` high and `bwe_n` high, no lane is written and the access is a read.
- R5: A start can come from either strobe (`cpu_strb_n` or `ctl_strb_n`, both active low). When `cpu_strb_n` is low, that cycle is always a read: the write inputs are ignored, even if `ctl_strb_n` is also low.
- R6: In a cycle after a start with no strobe low, `adv_n` low steps the two-bit burst count by one and accesses the next word. `adv_n` high accesses the same word again.
- R7: The two low address bits of a burst are the start bits plus the count modulo 4 when `lin_mode` is 1, and the start bits XOR the count when `lin_mode` is 0. The upper address bits stay fixed for the whole burst.
- R8: A start is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A start strobe with any other combination performs no access and ends a running burst.
- R9: While `sleep` is high, and for three cycles after it is released, accesses are ignored and the contents are kept. An access captured on the second edge after the release edge is still ignored. One captured on the third edge is served.
- R10: `oe_n` high forces `rvalid` to 0 and `rdata` to 0 without waiting for a clock. Lowering `oe_n` within the same cycle shows the word held in the output register.
- R11: A synchronous high `rst` ends any burst and clears the read pipeline. While no access is started after reset, `rvalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Word address sampled on a start |
| wdata | input | DW | Write data for the current access |
| cpu_strb_n | input | 1 | Processor start strobe, active low, read-only start |
| ctl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Enables the per-lane write inputs, active low |
| bw_n | input | DW/8 | Per-lane write selects, active low |
| lin_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low, combinational |
| rdata | output | DW | Read data, zero when not valid |
| rvalid | output | 1 | Read word present on `rdata` |

## Verification
The collisions that matter are a start strobe arriving in the same cycle as a write qualifier, and a start arriving in the same cycle as the end of the wake-up delay. The bench lowers both strobes together with `gw_n` low and expects the old word back, first in the pipelined result and then in a later single read. The write inputs are also asserted exactly on the last ignored wake-up edge, and the bench expects no change in the stored word, while an access one cycle later is served. A further collision tests the asynchronous output enable: `oe_n` is lowered inside the single cycle in which the output register holds a word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  localparam int BURST_W = 2;

  typedef struct packed {
    logic cpu_n;
    logic ctl_n;
    logic adv_n;
    logic ce1_n;
    logic ce2;
    logic ce3_n;
    logic gw_n;
    logic bwe_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cpu_n: 1'b1, ctl_n: 1'b1, adv_n: 1'b1,
                                ce1_n: 1'b1, ce2: 1'b0, ce3_n: 1'b1,
                                gw_n: 1'b1, bwe_n: 1'b1};

  // low address bits of a burst step, linear or interleaved
  function automatic logic [BURST_W-1:0] burst_low(input logic lin,
                                                   input logic [BURST_W-1:0] start,
                                                   input logic [BURST_W-1:0] cnt);
    return lin ? (start + cnt) : (start ^ cnt);
  endfunction

endpackage

// File: rtl/bsram_wake.sv
module bsram_wake #(
  parameter int WAKE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic ready
);
  localparam int CNTW = $clog2(WAKE + 1);

  logic            slp_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slp_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      slp_q <= sleep;
      if (slp_q)
        cnt_q <= CNTW'(WAKE);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = !slp_q && (cnt_q == '0);

  // R9: the edge that ends sleep never opens the part at once
  p_wake_gap_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(slp_q) |-> !ready);
  // R9: a sleeping part stays closed on the next cycle as well
  p_sleep_closed_r9: assert property (@(posedge clk) disable iff (rst)
    slp_q |=> !ready);

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
  import bsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready,
  input  logic          lin_mode,
  input  logic          start,
  input  logic          cpu_start,
  input  logic          sel,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  output logic          acc,
  output logic          wr_ok,
  output logic [AW-1:0] acc_addr
);
  logic               act_q, act_d;
  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    acc    = 1'b0;
    wr_ok  = 1'b0;
    if (!ready) begin
      act_d = 1'b0;
    end else if (start) begin
      if (sel) begin
        act_d  = 1'b1;
        base_d = addr_in;
        cnt_d  = '0;
        acc    = 1'b1;
        wr_ok  = !cpu_start;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      acc   = 1'b1;
      wr_ok = 1'b1;
      if (adv) cnt_d = cnt_q + 1'b1;
    end
  end

  assign acc_addr = {base_d[AW-1:BURST_W],
                     burst_low(lin_mode, base_d[BURST_W-1:0], cnt_d)};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

  // R6: an advance cycle moves the count by exactly one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && act_q && !start && adv) |=> cnt_q == BURST_W'($past(cnt_q) + 1'b1));
  // R7: a continuing burst never leaves its aligned group
  p_group_r7: assert property (@(posedge clk) disable iff (rst)
    (act_q && !start) |-> acc_addr[AW-1:BURST_W] == base_q[AW-1:BURST_W]);
  // R8: a start without selection leaves no burst running
  p_desel_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && start && !sel) |=> !act_q);

endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic [DW/8-1:0] we,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   dout_q
);
  localparam int LANES = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (we[i]) mem[addr][i*8 +: 8] <= wdata[i*8 +: 8];
    if (rd) dout_q <= mem[addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int WAKE = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            cpu_strb_n,
  input  logic            ctl_strb_n,
  input  logic            adv_n,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            gw_n,
  input  logic            bwe_n,
  input  logic [DW/8-1:0] bw_n,
  input  logic            lin_mode,
  input  logic            sleep,
  input  logic            oe_n,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int LANES = DW / 8;

  // input capture stage
  ctl_t             ctl_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] bw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_IDLE;
      bw_q  <= '1;
    end else begin
      ctl_q <= '{cpu_n: cpu_strb_n, ctl_n: ctl_strb_n, adv_n: adv_n,
                 ce1_n: ce1_n, ce2: ce2, ce3_n: ce3_n,
                 gw_n: gw_n, bwe_n: bwe_n};
      bw_q  <= bw_n;
    end
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  logic ready;
  bsram_wake #(.WAKE(WAKE)) u_wake (
    .clk(clk), .rst(rst), .sleep(sleep), .ready(ready)
  );

  logic          acc, wr_ok, start, cpu_start, sel;
  logic [AW-1:0] acc_addr;

  assign cpu_start = !ctl_q.cpu_n;
  assign start     = cpu_start || !ctl_q.ctl_n;
  assign sel       = !ctl_q.ce1_n && ctl_q.ce2 && !ctl_q.ce3_n;

  bsram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .ready(ready), .lin_mode(lin_mode),
    .start(start), .cpu_start(cpu_start), .sel(sel), .adv(!ctl_q.adv_n),
    .addr_in(addr_q), .acc(acc), .wr_ok(wr_ok), .acc_addr(acc_addr)
  );

  // lane write qualification
  logic [LANES-1:0] lane_we;
  logic             rd_req;

  always_comb begin
    if (!ctl_q.gw_n)       lane_we = '1;
    else if (!ctl_q.bwe_n) lane_we = ~bw_q;
    else                   lane_we = '0;
    if (!(acc && wr_ok))   lane_we = '0;
  end

  assign rd_req = acc && (lane_we == '0);

  logic [DW-1:0] core_q;
  bsram_core #(.AW(AW), .DW(DW)) u_core (
    .clk(clk), .we(lane_we), .rd(rd_req), .addr(acc_addr),
    .wdata(wdata_q), .dout_q(core_q)
  );

  // output register stage
  logic          rd1_q, vld_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1_q <= 1'b0;
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      rd1_q <= rd_req;
      vld_q <= rd1_q;
      if (rd1_q) out_q <= core_q;
    end
  end

  assign rvalid = vld_q && !oe_n;
  assign rdata  = rvalid ? out_q : '0;

  // R5: a processor start never writes
  p_cpu_read_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && cpu_start) |-> lane_we == '0);
  // R9: no access reaches the array while closed
  p_closed_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !acc);
  // R1: an output word always stems from a read two edges back
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(rd_req, 2));
  // R10: a disabled output never reports a word
  p_oe_r10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !rvalid);

endmodule

// File: tb/burst_sram_tb.sv
`timescale 1ns/100ps
module burst_sram_tb;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic lin_mode = 1'b1, sleep = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  always #2.5 clk = ~clk;

  burst_sram #(.AW(AW), .DW(DW), .WAKE(3)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .cpu_strb_n(cpu_n), .ctl_strb_n(ctl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lin_mode(lin_mode), .sleep(sleep), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] shadow [0:(1<<AW)-1];

  // {addr[15:0], data[31:0], gw_n, bwe_n, bw_n[3:0]}
  localparam logic [53:0] VEC [0:7] = '{
    {16'h0010, 32'hA1B2C3D4, 1'b0, 1'b1, 4'b1111},
    {16'h0011, 32'h11223344, 1'b1, 1'b0, 4'b0000},
    {16'h0010, 32'hFFFFFFFF, 1'b1, 1'b0, 4'b1110},
    {16'h0010, 32'h00000000, 1'b1, 1'b0, 4'b0111},
    {16'h0011, 32'h55555555, 1'b1, 1'b1, 4'b0000},
    {16'h0012, 32'hDEADBEEF, 1'b0, 1'b0, 4'b1111},
    {16'h0012, 32'h00000000, 1'b1, 1'b0, 4'b1001},
    {16'h0013, 32'hCAFEF00D, 1'b0, 1'b1, 4'b1010}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
  endtask

  task automatic desel();
    idle(); cpu_n = 1'b0; ce1_n = 1'b1;
  endtask

  function automatic logic [1:0] ord(input logic lin, input logic [1:0] s, input logic [1:0] k);
    return lin ? 2'(s + k) : (s ^ k);
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] bw);
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !bw[i])) shadow[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic wr_one(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic g, input logic b, input logic [3:0] bw);
    idle(); ctl_n = 1'b0; addr = a; wdata = d; gw_n = g; bwe_n = b; bw_n = bw;
    tick(); desel(); tick(); idle();
  endtask

  task automatic rd_one(input string tag, input logic [AW-1:0] a);
    idle(); cpu_n = 1'b0; addr = a;
    tick(); desel(); tick(); idle(); tick();
    check({tag, " rvalid"}, 32'(rvalid), 32'd1);
    check({tag, " data"}, rdata, shadow[a]);
    tick();
    check({tag, " R1 single pulse"}, 32'(rvalid), 32'd0);
  endtask

  task automatic wburst(input logic [AW-1:0] base, input logic [1:0] s, input logic lin);
    lin_mode = lin;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin ctl_n = 1'b0; addr = base + AW'(s); end
      else adv_n = 1'b0;
      gw_n = 1'b0; wdata = 32'h5000_0000 | 32'(base) << 8 | 32'(k);
      shadow[base + AW'(ord(lin, s, 2'(k)))] = wdata;
      tick();
    end
    desel(); tick(); idle();
  endtask

  task automatic rburst(input string tag, input logic [AW-1:0] base,
                        input logic [1:0] s, input logic lin);
    lin_mode = lin;
    for (int j = 0; j < 8; j++) begin
      if (j >= 3 && j <= 6) begin
        check({tag, " R1 burst valid"}, 32'(rvalid), 32'd1);
        check({tag, " R7 burst order"}, rdata, shadow[base + AW'(ord(lin, s, 2'(j-3)))]);
      end
      if (j == 7) check({tag, " R8 burst ended"}, 32'(rvalid), 32'd0);
      idle();
      if (j == 0) begin cpu_n = 1'b0; addr = base + AW'(s); end
      else if (j <= 3) adv_n = 1'b0;
      else if (j == 4) desel();
      tick();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R11: reset state
    check("R11 reset rvalid", 32'(rvalid), 32'd0);
    check("R11 reset rdata", rdata, 32'd0);

    // table of lane-write vectors
    for (int i = 0; i < 8; i++) begin
      logic [53:0] v;
      logic [15:0] va;
      string tg;
      v  = VEC[i];
      va = v[53:38];
      tg = !v[5] ? "R3" : (!v[4] ? "R2" : "R4");
      wr_one(va[AW-1:0], v[37:6], v[5], v[4], v[3:0]);
      model_wr(va[AW-1:0], v[37:6], v[5], v[4], v[3:0]);
      rd_one(tg, va[AW-1:0]);
    end
    check("R2 lane mix 0x10", shadow[10'h10], 32'h00B2C3FF);

    // R7: write bursts in both orders, check each word singly
    wburst(10'h020, 2'd1, 1'b1);
    for (int k = 0; k < 4; k++) rd_one("R7 linear word", 10'h020 + AW'(k));
    wburst(10'h024, 2'd1, 1'b0);
    for (int k = 0; k < 4; k++) rd_one("R7 interleave word", 10'h024 + AW'(k));
    check("R7 interleave place", shadow[10'h024], 32'h5000_2401);

    // R6/R7: read bursts with pipelined output
    rburst("lin", 10'h020, 2'd3, 1'b1);
    rburst("ilv", 10'h024, 2'd3, 1'b0);

    // R6: hold then advance
    lin_mode = 1'b1;
    for (int j = 0; j < 6; j++) begin
      if (j == 3) check("R6 first", rdata, shadow[10'h020]);
      if (j == 4) check("R6 hold repeats", rdata, shadow[10'h020]);
      if (j == 5) check("R6 advance", rdata, shadow[10'h021]);
      idle();
      if (j == 0) begin cpu_n = 1'b0; addr = 10'h020; end
      else if (j == 2) adv_n = 1'b0;
      else if (j == 3) desel();
      tick();
    end
    idle(); tick();

    // R5: both strobes with global write, processor wins and reads
    idle(); cpu_n = 1'b0; ctl_n = 1'b0; addr = 10'h010; gw_n = 1'b0; wdata = 32'h0BADF00D;
    tick(); desel(); tick(); idle(); tick();
    check("R5 priority read valid", 32'(rvalid), 32'd1);
    check("R5 priority read data", rdata, shadow[10'h010]);
    tick();
    rd_one("R5 no write", 10'h010);
    // R5: controller strobe alone writes
    wr_one(10'h014, 32'h13572468, 1'b0, 1'b1, 4'hF);
    model_wr(10'h014, 32'h13572468, 1'b0, 1'b1, 4'hF);
    rd_one("R5 ctl write", 10'h014);

    // R8: each wrong select blocks the access
    for (int v = 0; v < 3; v++) begin
      idle(); ctl_n = 1'b0; addr = 10'h011; gw_n = 1'b0; wdata = 32'h0;
      if (v == 0) ce1_n = 1'b1;
      if (v == 1) ce2 = 1'b0;
      if (v == 2) ce3_n = 1'b1;
      tick(); idle(); tick(); tick();
      check("R8 deselect no output", 32'(rvalid), 32'd0);
      tick();
      rd_one("R8 deselect no write", 10'h011);
    end

    // R9: sleep
    idle(); sleep = 1'b1; ctl_n = 1'b0; addr = 10'h012; gw_n = 1'b0; wdata = 32'h0;
    tick(); idle(); cpu_n = 1'b0; addr = 10'h012;
    tick(); idle(); tick(); tick();
    check("R9 sleep read ignored", 32'(rvalid), 32'd0);
    tick();
    sleep = 1'b0;
    tick(); tick();
    idle(); ctl_n = 1'b0; addr = 10'h012; gw_n = 1'b0; wdata = 32'h0;
    tick(); idle(); tick();
    rd_one("R9 retained after wake", 10'h012);
    check("R9 value kept", shadow[10'h012], 32'hDE0000EF);
    wr_one(10'h012, 32'h24681357, 1'b0, 1'b1, 4'hF);
    model_wr(10'h012, 32'h24681357, 1'b0, 1'b1, 4'hF);
    rd_one("R9 awake write", 10'h012);

    // R10: output enable acts without a clock
    oe_n = 1'b1;
    idle(); cpu_n = 1'b0; addr = 10'h013;
    tick(); desel(); tick(); idle(); tick();
    check("R10 disabled rvalid", 32'(rvalid), 32'd0);
    check("R10 disabled rdata", rdata, 32'd0);
    #1 oe_n = 1'b0;
    #0.5;
    check("R10 enable rvalid", 32'(rvalid), 32'd1);
    check("R10 enable rdata", rdata, shadow[10'h013]);
    tick();

    // R11: reset in the middle of a burst
    idle(); cpu_n = 1'b0; addr = 10'h020;
    tick(); idle(); adv_n = 1'b0;
    tick(); rst = 1'b1; idle();
    tick(); tick(); rst = 1'b0;
    for (int j = 0; j < 3; j++) begin
      tick();
      check("R11 burst cleared", 32'(rvalid), 32'd0);
    end

    finish_run();
  end

endmodule